// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Masking

This block sits between a single-word internal request port and an external asynchronous static RAM of 2^18 words by 16 bits. It turns each accepted read or write into a cycle-counted sequence on the memory's active-low chip-enable, output-enable, write-enable and two byte-select pins. It also drives the address and a split data bus (output value, output enable, input value) that the pad ring turns into a tri-state bus. Setup, write-pulse, hold, read-access and bus-turnaround lengths are parameters in clock cycles, so slower memory speed grades only need new counts.

A write stores only the byte lanes whose mask bit is set: lane 0 is data bits 7:0 and lane 1 is bits 15:8. By default the write window is ended by the byte selects, with write enable held low through back-to-back writes. A parameter instead selects write-enable-terminated writes. Reads return data with a one-cycle valid pulse, and lanes that were not selected come back as zero. While no operation is in progress the chip is deselected (standby).

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip enable, output enable, write enable and both byte selects are high, the data bus is not driven, `ready_o` is high and `rvalid_o` is low.
- R2: When no request is in progress, chip enable is high and all other strobes are high, with the data bus released.
- R3: A write with mask `be_i` updates only the lanes whose mask bit is 1 (bit 0 = data[7:0], bit 1 = data[15:8]); the other lanes of that word keep their earlier contents.
- R4: Each write window (chip enable, write enable and at least one byte select all low) lasts exactly `T_PULSE` cycles. The data bus is driven for the whole window, and address and data do not change during it or in the cycle in which it ends.
- R5: Output enable is never low while the controller drives the data bus, and output enable is high in the cycle before write enable falls.
- R6: Output enable falls only after the data bus has been released for at least `T_TURN` consecutive cycles.
- R7: A read with a nonzero mask holds chip enable and output enable low and write enable high. `rvalid_o` rises `T_ACCESS` cycles after the acceptance cycle (from idle) and stays high for one cycle. `rdata_o` carries the selected lanes, with unselected lanes zero.
- R8: A write with mask 2'b00 completes at acceptance: no strobe moves, no write window occurs and `ready_o` is still high in the next cycle.
- R9: A read with mask 2'b00 pulses `rvalid_o` in the cycle after acceptance with `rdata_o` zero, without lowering chip enable.
- R10: In the default byte-select-terminated mode, a write accepted in the last hold cycle of a previous write reuses the same low write-enable period: two back-to-back writes give two write windows and only one falling edge of write enable.
- R11: A request is accepted only on a cycle where `ready_o` is high; `ready_o` is low in the cycle after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte lane mask, bit 0 = low byte |
| ready_o | output | 1 | Request accepted when high with req_i |
| rdata_o | output | 16 | Read data, unselected lanes zero |
| rvalid_o | output | 1 | One-cycle read data valid |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_bs_no | output | 2 | Byte selects, active low, bit 0 = low byte |
| sram_addr_o | output | 18 | Memory address |
| sram_dq_o | output | 16 | Data bus output value |
| sram_dq_oe_o | output | 1 | Data bus output enable to the pad |
| sram_dq_i | input | 16 | Data bus input value |

## Verification
The bench drives full-word, single-lane and empty-mask patterns, both writes and reads. A full-word write followed by partial overwrites of the same word distinguishes correct lane gating from whole-word writes. Reads with a single lane set, against a memory model that puts filler on undriven lanes, show whether unselected lanes are zeroed. Back-to-back writes with no idle gap, and a read accepted at the end of a write, separate the chained write-enable path and the turnaround path from the plain idle-to-operation sequences.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_TURN
  } st_e;

  // which strobe closes the write window
  typedef enum logic {
    TERM_BYTE_SEL,
    TERM_WRITE_EN
  } term_e;
endpackage

// File: rtl/sramc_cnt.sv
module sramc_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int NB       = DW / 8,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 5,
  parameter int T_TURN   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  output logic          ready_o,
  output st_e           st_d_o,
  output logic [AW-1:0] addr_d_o,
  output logic [DW-1:0] wdata_d_o,
  output logic [NB-1:0] be_d_o,
  output logic [NB-1:0] be_q_o,
  output logic          cap_o,
  output logic          null_rd_o
);
  localparam int M1    = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int M2    = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M3 > T_TURN) ? M3 : T_TURN;
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam logic [CNT_W-1:0] SET_L = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] PUL_L = CNT_W'(T_PULSE - 1);
  localparam logic [CNT_W-1:0] HLD_L = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] ACC_L = CNT_W'(T_ACCESS - 1);
  localparam logic [CNT_W-1:0] TRN_L = CNT_W'(T_TURN - 1);

  st_e              st_q, st_d;
  logic             pend_q, pend_d;
  logic             done, ld, accept;
  logic [CNT_W-1:0] ldv;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [NB-1:0]    be_q;

  sramc_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ldv),
    .done_o (done)
  );

  assign ready_o = (st_q == ST_IDLE) || (st_q == ST_WHLD && done);
  assign accept  = req_i && ready_o;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    ld        = 1'b0;
    ldv       = '0;
    null_rd_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (be_i == '0) begin
          null_rd_o = !we_i;
        end else if (we_i) begin
          st_d = ST_WSET; ld = 1'b1; ldv = SET_L;
        end else begin
          st_d = ST_RACC; ld = 1'b1; ldv = ACC_L;
        end
      end
      ST_WSET: if (done) begin st_d = ST_WPUL; ld = 1'b1; ldv = PUL_L; end
      ST_WPUL: if (done) begin st_d = ST_WHLD; ld = 1'b1; ldv = HLD_L; end
      ST_WHLD: if (done) begin
        if (accept && we_i && be_i != '0) begin
          st_d = ST_WSET; ld = 1'b1; ldv = SET_L;
        end else begin
          st_d = ST_TURN; ld = 1'b1; ldv = TRN_L;
          if (accept && !we_i) begin
            if (be_i == '0) null_rd_o = 1'b1;
            else            pend_d    = 1'b1;
          end
        end
      end
      ST_RACC: if (done) begin st_d = ST_TURN; ld = 1'b1; ldv = TRN_L; end
      ST_TURN: if (done) begin
        if (pend_q) begin
          st_d = ST_RACC; ld = 1'b1; ldv = ACC_L; pend_d = 1'b0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign addr_d_o  = accept ? addr_i  : addr_q;
  assign wdata_d_o = accept ? wdata_i : wdata_q;
  assign be_d_o    = accept ? be_i    : be_q;
  assign be_q_o    = be_q;
  assign st_d_o    = st_d;
  assign cap_o     = (st_q == ST_RACC) && done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d_o;
      wdata_q <= wdata_d_o;
      be_q    <= be_d_o;
    end
  end

  // R8: empty-mask write leaves the sequencer idle
  a_r8_null_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && we_i && be_i == '0) |=> (st_q == ST_IDLE));

  // R11: a started write makes the port busy
  a_r11_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && we_i && be_i != '0) |=> !ready_o);
endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int    AW   = 18,
  parameter int    DW   = 16,
  parameter int    NB   = DW / 8,
  parameter term_e TERM = TERM_BYTE_SEL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  st_e           st_d_i,
  input  logic [AW-1:0] addr_d_i,
  input  logic [DW-1:0] wdata_d_i,
  input  logic [NB-1:0] be_d_i,
  input  logic [NB-1:0] be_q_i,
  input  logic          cap_i,
  input  logic          null_rd_i,
  input  logic [DW-1:0] dq_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [NB-1:0] bs_n_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          wr_ph, rd_ph, ce_n_d, we_n_d;
  logic [NB-1:0] bs_n_d;
  logic [DW-1:0] rd_m;

  assign wr_ph  = (st_d_i == ST_WSET) || (st_d_i == ST_WPUL) || (st_d_i == ST_WHLD);
  assign rd_ph  = (st_d_i == ST_RACC);
  assign ce_n_d = !(wr_ph || rd_ph);

  if (TERM == TERM_BYTE_SEL) begin : g_bsel
    // write enable spans the whole write, byte selects frame the pulse
    assign we_n_d = !wr_ph;
    for (genvar i = 0; i < NB; i++) begin : g_lane
      assign bs_n_d[i] = !(be_d_i[i] && ((st_d_i == ST_WPUL) || rd_ph));
    end
  end else begin : g_wen
    assign we_n_d = !(st_d_i == ST_WPUL);
    for (genvar i = 0; i < NB; i++) begin : g_lane
      assign bs_n_d[i] = !(be_d_i[i] && (wr_ph || rd_ph));
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_rd
    assign rd_m[i*8 +: 8] = be_q_i[i] ? dq_i[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      bs_n_o   <= '1;
      addr_o   <= '0;
      dq_o     <= '0;
      dq_oe_o  <= 1'b0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      ce_n_o   <= ce_n_d;
      oe_n_o   <= !rd_ph;
      we_n_o   <= we_n_d;
      bs_n_o   <= bs_n_d;
      addr_o   <= addr_d_i;
      dq_o     <= wdata_d_i;
      dq_oe_o  <= wr_ph;
      rvalid_o <= cap_i || null_rd_i;
      if (cap_i)          rdata_o <= rd_m;
      else if (null_rd_i) rdata_o <= '0;
    end
  end

  a_r5_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && !oe_n_o));

  a_r5_oe_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> $past(oe_n_o));

  a_r4_we_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !ce_n_o);

  a_r7_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (we_n_o && !ce_n_o));

  a_r6_oe_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_o) |-> !$past(dq_oe_o));

  if (TERM == TERM_BYTE_SEL) begin : g_chk_bsel
    a_r10_bs_under_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dq_oe_o && bs_n_o != '1) |-> !we_n_o);
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sramc_pkg::*;
#(
  parameter int    ADDR_W   = 18,
  parameter int    DATA_W   = 16,
  parameter int    T_SETUP  = 1,
  parameter int    T_PULSE  = 2,
  parameter int    T_HOLD   = 1,
  parameter int    T_ACCESS = 5,
  parameter int    T_TURN   = 2,
  parameter term_e TERM     = TERM_BYTE_SEL
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [DATA_W/8-1:0]  be_i,
  output logic                 ready_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  output logic                 sram_ce_no,
  output logic                 sram_oe_no,
  output logic                 sram_we_no,
  output logic [DATA_W/8-1:0]  sram_bs_no,
  output logic [ADDR_W-1:0]    sram_addr_o,
  output logic [DATA_W-1:0]    sram_dq_o,
  output logic                 sram_dq_oe_o,
  input  logic [DATA_W-1:0]    sram_dq_i
);
  localparam int NB = DATA_W / 8;

  st_e             st_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [NB-1:0]     be_d, be_q;
  logic              cap, null_rd;

  sramc_fsm #(
    .AW(ADDR_W), .DW(DATA_W), .NB(NB),
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_ACCESS(T_ACCESS), .T_TURN(T_TURN)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .be_i      (be_i),
    .ready_o   (ready_o),
    .st_d_o    (st_d),
    .addr_d_o  (addr_d),
    .wdata_d_o (wdata_d),
    .be_d_o    (be_d),
    .be_q_o    (be_q),
    .cap_o     (cap),
    .null_rd_o (null_rd)
  );

  sramc_pins #(
    .AW(ADDR_W), .DW(DATA_W), .NB(NB), .TERM(TERM)
  ) i_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_d_i    (st_d),
    .addr_d_i  (addr_d),
    .wdata_d_i (wdata_d),
    .be_d_i    (be_d),
    .be_q_i    (be_q),
    .cap_i     (cap),
    .null_rd_i (null_rd),
    .dq_i      (sram_dq_i),
    .ce_n_o    (sram_ce_no),
    .oe_n_o    (sram_oe_no),
    .we_n_o    (sram_we_no),
    .bs_n_o    (sram_bs_no),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .dq_oe_o   (sram_dq_oe_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  // R2: chip is only selected while the port is busy or finishing a write
  a_r2_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sram_dq_oe_o == 1'b0) |-> (sram_ce_no && sram_oe_no));
endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int T_SETUP  = 1;
  localparam int T_PULSE  = 2;
  localparam int T_HOLD   = 1;
  localparam int T_ACCESS = 5;
  localparam int T_TURN   = 2;
  localparam int NV       = 13;

  // {we, be[1:0], addr[17:0], wdata[15:0], gap}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 2'b11, 18'h00010, 16'h1234, 1'b0},
    {1'b1, 2'b11, 18'h3FFFF, 16'hBEEF, 1'b1},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 1'b0},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 1'b1},
    {1'b1, 2'b01, 18'h00010, 16'h00AA, 1'b0},
    {1'b1, 2'b10, 18'h00010, 16'h5500, 1'b0},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 1'b1},
    {1'b0, 2'b01, 18'h3FFFF, 16'h0000, 1'b0},
    {1'b0, 2'b10, 18'h3FFFF, 16'h0000, 1'b1},
    {1'b1, 2'b00, 18'h00010, 16'hFFFF, 1'b1},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 1'b1},
    {1'b1, 2'b11, 18'h00000, 16'h0F0F, 1'b0},
    {1'b0, 2'b11, 18'h00000, 16'h0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [1:0]  bs_n;
  logic [17:0] s_addr;

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  sram_ctrl #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_ACCESS(T_ACCESS), .T_TURN(T_TURN)
  ) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .sram_ce_no(ce_n), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_bs_no(bs_n), .sram_addr_o(s_addr),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // memory model driven only by the pins, and a request-level reference
  logic [15:0] sram [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] sram_rd(input logic [17:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_rd(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  always @(*) begin
    logic [15:0] w;
    w = sram_rd(s_addr);
    if (!ce_n && !oe_n && we_n) begin
      dq_i[7:0]  = !bs_n[0] ? w[7:0]  : 8'hA5;
      dq_i[15:8] = !bs_n[1] ? w[15:8] : 8'hA5;
    end else begin
      dq_i = 16'hDEAD;
    end
  end

  // pin monitor
  logic        p_we, p_oe, p_win;
  logic [1:0]  p_bs;
  logic [17:0] p_addr;
  logic [15:0] p_dq;
  int win_len, rel, we_falls, windows, v4, v5, v6;
  logic [15:0] got_q [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_we = 1'b1; p_oe = 1'b1; p_win = 1'b0; p_bs = 2'b11;
      p_addr = '0; p_dq = '0; win_len = 0; rel = 100;
      we_falls = 0; windows = 0; v4 = 0; v5 = 0; v6 = 0;
    end else begin
      logic win;
      win = !ce_n && !we_n && (bs_n != 2'b11);
      if (!oe_n && dq_oe) v5++;
      if (p_we && !we_n && !p_oe) v5++;
      if (p_oe && !oe_n && rel < T_TURN) v6++;
      if (win) begin
        if (!dq_oe) v4++;
        if (p_win && (s_addr != p_addr || dq_o != p_dq || bs_n != p_bs)) v4++;
        win_len++;
      end
      if (p_win && !win) begin
        logic [15:0] m;
        if (s_addr != p_addr || dq_o != p_dq || !dq_oe) v4++;
        if (win_len != T_PULSE) v4++;
        m = sram_rd(p_addr);
        if (!p_bs[0]) m[7:0]  = p_dq[7:0];
        if (!p_bs[1]) m[15:8] = p_dq[15:8];
        sram[int'(p_addr)] = m;
        windows++;
        win_len = 0;
      end
      if (p_we && !we_n) we_falls++;
      rel = dq_oe ? 0 : rel + 1;
      if (rvalid) got_q.push_back(rdata);
      p_we = we_n; p_oe = oe_n; p_win = win; p_bs = bs_n;
      p_addr = s_addr; p_dq = dq_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] b, input logic [17:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = w; be = b; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    if (w) begin
      logic [15:0] m;
      m = ref_rd(a);
      m = (m & ~lane_mask(b)) | (d & lane_mask(b));
      ref_mem[int'(a)] = m;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [17:0] a, input logic [1:0] b, input string tag);
    int n;
    issue(1'b0, b, a, 16'h0000);
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!rvalid && n < 60) begin @(negedge clk); n++; end
    chk(tag, rdata, ref_rd(a) & lane_mask(b));
  endtask

  initial begin
    logic [15:0] exp_q [$];
    string       tag_q [$];
    int n, wf0, w0;

    #9;
    // R1 under reset
    chk("R1 ce_n in reset", ce_n, 1'b1);
    chk("R1 strobes in reset", {oe_n, we_n, bs_n}, 4'hF);
    chk("R1 bus released in reset", dq_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1'b1);
    chk("R1 rvalid after reset", rvalid, 1'b0);
    chk("R1 strobes after reset", {ce_n, oe_n, we_n, bs_n}, 5'h1F);

    // vector walk
    got_q.delete();
    for (int i = 0; i < NV; i++) begin
      logic        v_we, v_gap;
      logic [1:0]  v_be;
      logic [17:0] v_addr;
      logic [15:0] v_wd;
      {v_we, v_be, v_addr, v_wd, v_gap} = VEC[i];
      issue(v_we, v_be, v_addr, v_wd);
      if (!v_we) begin
        exp_q.push_back(ref_rd(v_addr) & lane_mask(v_be));
        tag_q.push_back(v_be == 2'b11 ? "R3 read-back" : "R7 lane zeroing");
      end
      if (v_gap) idle(4);
    end
    idle(40);
    chk("R7 read count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(tag_q[i], got_q[i], exp_q[i]);

    // R7 latency, strobes and single pulse
    issue(1'b0, 2'b11, 18'h00010, 16'h0000);
    @(negedge clk);
    req = 1'b0;
    chk("R7 read strobes", {ce_n, oe_n, we_n}, 3'b001);
    n = 0;
    while (!rvalid && n < 60) begin @(negedge clk); n++; end
    chk("R7 rvalid latency", n, T_ACCESS);
    chk("R7 read data", rdata, ref_rd(18'h00010));
    @(negedge clk);
    chk("R7 rvalid one cycle", rvalid, 1'b0);
    idle(6);

    // R9 empty-mask read
    issue(1'b0, 2'b00, 18'h3FFFF, 16'h0000);
    @(negedge clk);
    req = 1'b0;
    chk("R9 rvalid next cycle", rvalid, 1'b1);
    chk("R9 zero data", rdata, 16'h0000);
    chk("R9 chip not selected", ce_n, 1'b1);
    @(negedge clk);
    chk("R9 single pulse", rvalid, 1'b0);

    // R8 empty-mask write
    w0 = windows;
    issue(1'b1, 2'b00, 18'h3FFFF, 16'h0000);
    @(negedge clk);
    req = 1'b0;
    chk("R8 ready stays high", ready, 1'b1);
    chk("R8 no strobe", {ce_n, we_n, bs_n}, 4'hF);
    idle(6);
    chk("R8 no write window", windows - w0, 0);
    rd_chk(18'h3FFFF, 2'b11, "R8 word unchanged");
    idle(6);

    // R10 / R11 chained writes
    wf0 = we_falls;
    w0  = windows;
    issue(1'b1, 2'b11, 18'h00100, 16'hC0DE);
    @(negedge clk);
    chk("R11 busy after write accept", ready, 1'b0);
    issue(1'b1, 2'b10, 18'h00101, 16'h7700);
    idle(12);
    chk("R10 single write-enable fall", we_falls - wf0, 1);
    chk("R10 two write windows", windows - w0, 2);
    rd_chk(18'h00100, 2'b11, "R10 first word");
    idle(6);
    rd_chk(18'h00101, 2'b11, "R3 upper lane only");
    idle(10);

    // R2 standby
    chk("R2 standby strobes", {ce_n, oe_n, we_n, bs_n}, 5'h1F);
    chk("R2 bus released", dq_oe, 1'b0);

    chk("R4 write window protocol", v4, 0);
    chk("R5 output enable ordering", v5, 0);
    chk("R6 turnaround", v6, 0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule